// File: doc/BRIEF.md
# Nibble-Oriented Synchronous Serial Port

This block is the clock-synchronous serial channel of a small 4-bit controller. Software fills an internal buffer of 4-bit nibbles, sets how many nibbles to move, the bit-rate divider and the clock polarity, and then pulses a start input. The block then shifts the nibbles out on a transmit data line, with a transmit clock line beside it. At the same time it shifts in the same number of nibbles from a receive data line, timed by a receive clock line that it also drives. Each received nibble overwrites the buffer entry whose contents were just sent.

Inside every nibble the bits move least significant first. The nibbles move in buffer order from entry 0 upward. One polarity bit sets the idle level of both serial clocks, and with it the edge on which data is latched. A busy output covers the whole transfer, and a one-cycle completion pulse tells the interrupt logic that the last bit has gone.

The host reaches everything through one nibble-wide write port and one combinational read port. The address MSB selects the buffer. With the MSB clear, the two lowest address bits select a configuration register: 0 is the low nibble of the length, 1 is the high nibble of the length, 2 is the speed divider, and bit 0 of address 3 is the clock polarity. The other configuration addresses alias onto these four.

Top module: `nib_sync_serial`

## Requirements
- R1: After reset, busy and done are 0, both serial clocks and the transmit data line are 1, and the registers read back as length low 2, length high 0, speed 0 and mode 0.
- R2: With the length left at its reset value, one transfer moves 2 nibbles, which is 8 bits.
- R3: The transfer length in nibbles is high*16 + low. A value of 0, or any value above the buffer depth, moves the whole buffer.
- R4: Transmit order is buffer entry 0 first and then increasing entries. Within each nibble, bit 0 goes first and bit 3 last.
- R5: The 4 bits received during nibble slot k are stored in buffer entry k, with the first received bit in bit 0. Entries beyond the transfer length keep their contents.
- R6: With polarity 0 the clocks idle high. A new data bit appears together with the falling edge, and receive data is sampled at the rising edge.
- R7: With polarity 1 the clocks idle low. A new data bit appears together with the rising edge, and receive data is sampled at the falling edge.
- R8: Each clock level lasts speed+1 system cycles, so busy stays high for exactly 8*N*(speed+1) cycles for an N-nibble transfer.
- R9: Busy rises at the clock edge that samples start. Done is high for exactly one cycle, in the cycle where busy has just fallen.
- R10: While busy, writes to the buffer or to any configuration register, and further start pulses, have no effect.
- R11: The receive clock output always equals the transmit clock output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins a transfer when idle |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | log2(DEPTH)+1 | Host write address (MSB set selects the buffer) |
| wr_data | input | 4 | Host write nibble |
| rd_addr | input | log2(DEPTH)+1 | Host read address, same map as writes |
| rd_data | output | 4 | Combinational read data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| tx_data | output | 1 | Serial transmit data |
| tx_clk | output | 1 | Serial transmit clock |
| rx_clk | output | 1 | Serial receive clock |
| rx_data | input | 1 | Serial receive data |

## Verification
The bench builds the block with DEPTH=8 and DIV_W=2. With these values every divider setting (0 to 3), both polarities and every length from 0 to 10 can be swept, together with lengths whose high nibble is nonzero. That covers the full-buffer fallback for length 0 and for lengths above the depth, the untouched entries past a short transfer, and the exact half-period counts at each speed. The bench moves its receive data to a wrong value right after each sampling edge. This shows that the sample is taken on the idle-going edge rather than at any other point in the bit.

// File: rtl/nsp_pkg.sv
package nsp_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned LEN_W = 2 * NIB_W;

  typedef logic [NIB_W-1:0] nib_t;

  typedef enum logic [1:0] {
    CFG_LEN_LO = 2'd0,
    CFG_LEN_HI = 2'd1,
    CFG_SPEED  = 2'd2,
    CFG_MODE   = 2'd3
  } cfg_sel_e;

  localparam nib_t LEN_LO_RST = 4'd2;
endpackage

// File: rtl/nsp_regs.sv
module nsp_regs
  import nsp_pkg::*;
#(
  parameter  int unsigned DEPTH  = 16,
  parameter  int unsigned DIV_W  = 4,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  nib_t              host_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output nib_t              rd_data,
  input  logic              rx_we,
  input  logic [IDX_W-1:0]  rx_idx,
  input  nib_t              rx_wdata,
  input  logic [IDX_W-1:0]  tx_idx,
  output nib_t              tx_rdata,
  output logic [LEN_W-1:0]  len_q,
  output logic [DIV_W-1:0]  speed_q,
  output logic              pol_q,
  output logic [IDX_W-1:0]  last_idx
);
  logic             host_ok;
  logic             host_buf;
  nib_t             len_lo_q, len_lo_d;
  nib_t             len_hi_q, len_hi_d;
  logic [DIV_W-1:0] speed_d;
  logic             pol_d;
  logic             len_full;
  logic [DEPTH-1:0] ent_we;
  nib_t             ent_d [DEPTH];
  nib_t             buf_q [DEPTH];

  // host access is gated off for the whole transfer
  assign host_ok  = host_we && !busy;
  assign host_buf = host_addr[IDX_W];

  // configuration next state
  always_comb begin
    len_lo_d = len_lo_q;
    len_hi_d = len_hi_q;
    speed_d  = speed_q;
    pol_d    = pol_q;
    if (host_ok && !host_buf) begin
      case (cfg_sel_e'(host_addr[1:0]))
        CFG_LEN_LO: len_lo_d = host_wdata;
        CFG_LEN_HI: len_hi_d = host_wdata;
        CFG_SPEED:  speed_d  = host_wdata[DIV_W-1:0];
        CFG_MODE:   pol_d    = host_wdata[0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_lo_q <= LEN_LO_RST;
      len_hi_q <= '0;
      speed_q  <= '0;
      pol_q    <= 1'b0;
    end else begin
      len_lo_q <= len_lo_d;
      len_hi_q <= len_hi_d;
      speed_q  <= speed_d;
      pol_q    <= pol_d;
    end
  end

  // per-entry write select: receive path has priority (host is gated while busy)
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic host_hit;
    logic rx_hit;
    assign host_hit  = host_ok && host_buf && (host_addr[IDX_W-1:0] == IDX_W'(g));
    assign rx_hit    = rx_we && (rx_idx == IDX_W'(g));
    assign ent_we[g] = host_hit || rx_hit;
    assign ent_d[g]  = rx_hit ? rx_wdata : host_wdata;
  end

  // nibble storage, enable-written, no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_we[i]) buf_q[i] <= ent_d[i];
    end
  end

  assign tx_rdata = buf_q[tx_idx];

  always_comb begin
    if (rd_addr[IDX_W]) begin
      rd_data = buf_q[rd_addr[IDX_W-1:0]];
    end else begin
      case (cfg_sel_e'(rd_addr[1:0]))
        CFG_LEN_LO: rd_data = len_lo_q;
        CFG_LEN_HI: rd_data = len_hi_q;
        CFG_SPEED:  rd_data = NIB_W'(speed_q);
        CFG_MODE:   rd_data = {{(NIB_W-1){1'b0}}, pol_q};
        default:    rd_data = '0;
      endcase
    end
  end

  // effective length: zero or oversize means the full buffer
  assign len_q    = {len_hi_q, len_lo_q};
  assign len_full = (len_q == '0) || ({1'b0, len_q} > (LEN_W + 1)'(DEPTH));
  assign last_idx = len_full ? IDX_W'(DEPTH - 1) : IDX_W'(len_q - LEN_W'(1));
endmodule

// File: rtl/nsp_clkdiv.sv
module nsp_clkdiv #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  // one tick every div+1 cycles while running
  always_comb begin
    tick = run && (cnt_q == div);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/nsp_seq.sv
module nsp_seq
  import nsp_pkg::*;
#(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  logic             pol,
  input  logic [IDX_W-1:0] last_idx,
  input  nib_t             tx_rdata,
  input  logic             rx_in,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] tx_idx,
  output logic             rx_we,
  output logic [IDX_W-1:0] rx_idx,
  output nib_t             rx_wdata,
  output logic             ser_clk,
  output logic             ser_data
);
  logic             busy_q, busy_d;
  logic             half_q, half_d;   // 0: active level, 1: idle level
  logic [1:0]       bit_q, bit_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  nib_t             tx_sh_q, tx_sh_d;
  nib_t             rx_sh_q, rx_sh_d;
  logic             done_q, done_d;
  logic             sclk_q, sclk_d;
  logic             sdat_q, sdat_d;

  // fetch address: entry 0 when starting, the next entry while running
  assign tx_idx   = busy_q ? IDX_W'(idx_q + IDX_W'(1)) : '0;
  assign rx_idx   = idx_q;
  assign rx_wdata = {rx_in, rx_sh_q[NIB_W-1:1]};

  always_comb begin
    busy_d  = busy_q;
    half_d  = half_q;
    bit_d   = bit_q;
    idx_d   = idx_q;
    tx_sh_d = tx_sh_q;
    rx_sh_d = rx_sh_q;
    done_d  = 1'b0;
    rx_we   = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d  = 1'b1;
        half_d  = 1'b0;
        bit_d   = '0;
        idx_d   = '0;
        tx_sh_d = tx_rdata;
      end
    end else if (tick) begin
      if (!half_q) begin
        // clock returns to idle: latch edge
        half_d  = 1'b1;
        rx_sh_d = {rx_in, rx_sh_q[NIB_W-1:1]};
        rx_we   = (bit_q == 2'd3);
      end else begin
        // clock leaves idle: launch edge for the next bit
        half_d = 1'b0;
        if (bit_q == 2'd3) begin
          if (idx_q == last_idx) begin
            busy_d = 1'b0;
            done_d = 1'b1;
          end else begin
            idx_d   = IDX_W'(idx_q + IDX_W'(1));
            bit_d   = '0;
            tx_sh_d = tx_rdata;
          end
        end else begin
          bit_d   = bit_q + 2'd1;
          tx_sh_d = {1'b0, tx_sh_q[NIB_W-1:1]};
        end
      end
    end
    // registered pin levels; active level equals pol
    sclk_d = busy_d ? (half_d ? ~pol : pol) : ~pol;
    sdat_d = busy_d ? tx_sh_d[0] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      half_q  <= 1'b0;
      bit_q   <= '0;
      idx_q   <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      done_q  <= 1'b0;
      sclk_q  <= 1'b1;
      sdat_q  <= 1'b1;
    end else begin
      busy_q  <= busy_d;
      half_q  <= half_d;
      bit_q   <= bit_d;
      idx_q   <= idx_d;
      tx_sh_q <= tx_sh_d;
      rx_sh_q <= rx_sh_d;
      done_q  <= done_d;
      sclk_q  <= sclk_d;
      sdat_q  <= sdat_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign ser_clk  = sclk_q;
  assign ser_data = sdat_q;
endmodule

// File: rtl/nib_sync_serial.sv
module nib_sync_serial
  import nsp_pkg::*;
#(
  parameter  int unsigned DEPTH  = 16,
  parameter  int unsigned DIV_W  = 4,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [3:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [3:0]        rd_data,
  output logic              busy,
  output logic              done,
  output logic              tx_data,
  output logic              tx_clk,
  output logic              rx_clk,
  input  logic              rx_data
);
  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic             tick;
  logic             cfg_pol;
  logic [LEN_W-1:0] cfg_len;
  logic [DIV_W-1:0] cfg_speed;
  logic [IDX_W-1:0] last_idx;
  logic [IDX_W-1:0] tx_idx;
  logic [IDX_W-1:0] rx_idx;
  logic             rx_we;
  nib_t             tx_rdata;
  nib_t             rx_wdata;
  logic             ser_clk;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  nsp_regs #(.DEPTH(DEPTH), .DIV_W(DIV_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .busy      (busy),
    .host_we   (wr_en),
    .host_addr (wr_addr),
    .host_wdata(wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .rx_we     (rx_we),
    .rx_idx    (rx_idx),
    .rx_wdata  (rx_wdata),
    .tx_idx    (tx_idx),
    .tx_rdata  (tx_rdata),
    .len_q     (cfg_len),
    .speed_q   (cfg_speed),
    .pol_q     (cfg_pol),
    .last_idx  (last_idx)
  );

  nsp_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .run  (busy),
    .div  (cfg_speed),
    .tick (tick)
  );

  nsp_seq #(.DEPTH(DEPTH)) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (start),
    .tick    (tick),
    .pol     (cfg_pol),
    .last_idx(last_idx),
    .tx_rdata(tx_rdata),
    .rx_in   (rx_data),
    .busy    (busy),
    .done    (done),
    .tx_idx  (tx_idx),
    .rx_we   (rx_we),
    .rx_idx  (rx_idx),
    .rx_wdata(rx_wdata),
    .ser_clk (ser_clk),
    .ser_data(tx_data)
  );

  assign tx_clk = ser_clk;
  assign rx_clk = ser_clk;
endmodule

// File: rtl/nsp_checker.sv
module nsp_checker
  import nsp_pkg::*;
#(
  parameter int unsigned DIV_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             tx_clk,
  input logic             rx_clk,
  input logic             tx_data,
  input logic             pol,
  input logic [LEN_W-1:0] len,
  input logic [DIV_W-1:0] speed
);
  // R9: completion pulse lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: done appears exactly when busy drops
  a_r9_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10: configuration frozen during a transfer
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(len) && $stable(speed) && $stable(pol)));

  // R6 / R7: idle clock level is the inverse of the polarity bit, data idles high
  a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $stable(pol)) |-> ((tx_clk != pol) && tx_data));

  // R6 / R7: data moves only together with the launch (active-going) edge
  a_r7_launch_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(tx_data)) |-> (tx_clk == pol));

  // R11: both serial clocks track
  a_r11_clk_match: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clk == rx_clk);
endmodule

bind nib_sync_serial nsp_checker #(.DIV_W(DIV_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .busy   (busy),
  .done   (done),
  .tx_clk (tx_clk),
  .rx_clk (rx_clk),
  .tx_data(tx_data),
  .pol    (cfg_pol),
  .len    (cfg_len),
  .speed  (cfg_speed)
);

// File: tb/test_nib_sync_serial.sv
`timescale 1ns/1ps
module test_nib_sync_serial;
  localparam int DEPTH = 8;
  localparam int DIV_W = 2;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [3:0]    wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [3:0]    rd_data;
  logic          busy, done, tx_data, tx_clk, rx_clk;
  logic          rx_data = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;

  logic [3:0] tx_pat [DEPTH];
  logic [3:0] rx_pat [DEPTH];
  logic       got    [4*DEPTH];

  nib_sync_serial #(.DEPTH(DEPTH), .DIV_W(DIV_W)) i_nib_sync_serial (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .done(done), .tx_data(tx_data), .tx_clk(tx_clk), .rx_clk(rx_clk),
    .rx_data(rx_data)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic host_wr(input logic [AW-1:0] a, input logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic host_rd(input logic [AW-1:0] a, output logic [3:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  // one transfer with full checking; cfg=0 keeps the current configuration
  task automatic run_xfer(input bit cfg, input bit pol, input int spd,
                          input int lenraw, input int seed, input bit disturb);
    int n, h, busy_cyc, bits, run_len, trans, bad_half, clk_mis, done_early, bit_bad, ab, ae;
    logic prev;
    logic [3:0] v;
    n = (lenraw == 0 || lenraw > DEPTH) ? DEPTH : lenraw;
    h = spd + 1;
    for (int i = 0; i < DEPTH; i++) begin
      tx_pat[i] = 4'((seed * 3 + i * 5 + 1) & 15);
      rx_pat[i] = 4'((seed * 7 + i * 11 + 6) & 15);
      host_wr(AW'(8 + i), tx_pat[i]);
    end
    if (cfg) begin
      host_wr(4'd0, 4'(lenraw & 15));
      host_wr(4'd1, 4'((lenraw >> 4) & 15));
      host_wr(4'd2, 4'(spd));
      host_wr(4'd3, {3'b0, pol});
    end
    @(negedge clk);
    check(tx_clk == !pol && tx_data == 1'b1, pol ? "R7 idle before" : "R6 idle before",
          int'(tx_clk), int'(!pol));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 busy rises", int'(busy), 1);
    busy_cyc = 0; bits = 0; run_len = 0; trans = 0; bad_half = 0;
    clk_mis = 0; done_early = 0; prev = !pol;
    while (busy && busy_cyc < 4000) begin
      busy_cyc++;
      if (tx_clk != rx_clk) clk_mis++;
      if (done) done_early++;
      if (tx_clk != prev) begin
        if (trans > 0 && run_len != h) bad_half++;
        trans++;
        if (tx_clk == pol) begin
          if (bits < 4 * DEPTH) begin
            got[bits] = tx_data;
            rx_data = rx_pat[bits / 4][bits % 4];
          end
          bits++;
        end else if (bits > 0 && bits <= 4 * DEPTH) begin
          // spoil the line right after the sampling edge
          rx_data = ~rx_pat[(bits - 1) / 4][(bits - 1) % 4];
        end
        run_len = 1;
        prev = tx_clk;
      end else begin
        run_len++;
      end
      if (disturb && busy_cyc == 2) begin
        wr_en = 1'b1; wr_addr = 4'd0; wr_data = ~4'(lenraw & 15); start = 1'b1;
      end
      if (disturb && busy_cyc == 3) begin
        wr_addr = AW'(8 + DEPTH - 1); wr_data = ~tx_pat[DEPTH - 1]; start = 1'b0;
      end
      if (disturb && busy_cyc == 4) wr_en = 1'b0;
      @(negedge clk);
    end
    check(done == 1'b1, "R9 done at busy fall", int'(done), 1);
    check(done_early == 0, "R9 no early done", done_early, 0);
    check(busy_cyc == 8 * n * h, "R8 busy length", busy_cyc, 8 * n * h);
    check(bits == 4 * n, "R3 bit count", bits, 4 * n);
    check(bad_half == 0 && run_len == h, "R8 half period", run_len, h);
    check(clk_mis == 0, "R11 clocks equal", clk_mis, 0);
    bit_bad = 0; ab = 0; ae = 0;
    for (int b = 0; b < 4 * n && b < 4 * DEPTH; b++) begin
      if (got[b] != tx_pat[b / 4][b % 4]) begin
        if (bit_bad == 0) begin ab = int'(got[b]); ae = int'(tx_pat[b / 4][b % 4]); end
        bit_bad++;
      end
    end
    check(bit_bad == 0, "R4 transmit order", ab, ae);
    @(negedge clk);
    check(done == 1'b0, "R9 done one cycle", int'(done), 0);
    check(tx_clk == !pol && tx_data == 1'b1, pol ? "R7 idle after" : "R6 idle after",
          int'(tx_clk), int'(!pol));
    for (int i = 0; i < DEPTH; i++) begin
      host_rd(AW'(8 + i), v);
      if (i < n) check(v == rx_pat[i], pol ? "R5 R7 received nibble" : "R5 R6 received nibble",
                       int'(v), int'(rx_pat[i]));
      else       check(v == tx_pat[i], "R5 untouched entry", int'(v), int'(tx_pat[i]));
    end
    if (disturb) begin
      host_rd(4'd0, v);
      check(v == 4'(lenraw & 15), "R10 config write ignored", int'(v), lenraw & 15);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    report();
  end

  initial begin
    logic [3:0] v;
    int xid;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0 && done == 1'b0, "R1 busy/done", int'({busy, done}), 0);
    check(tx_clk == 1'b1 && rx_clk == 1'b1 && tx_data == 1'b1, "R1 pin levels",
          int'({tx_clk, rx_clk, tx_data}), 7);
    host_rd(4'd0, v); check(v == 4'd2, "R1 length low", int'(v), 2);
    host_rd(4'd1, v); check(v == 4'd0, "R1 length high", int'(v), 0);
    host_rd(4'd2, v); check(v == 4'd0, "R1 speed", int'(v), 0);
    host_rd(4'd3, v); check(v == 4'd0, "R1 mode", int'(v), 0);
    // R2 default length: 2 nibbles, speed 0, polarity 0
    run_xfer(1'b0, 1'b0, 0, 2, 5, 1'b0);
    // R3 R6 R7 R8 R10 sweep
    xid = 11;
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 4; s++) begin
        for (int l = 0; l < 13; l++) begin
          int lr;
          lr = (l < 11) ? l : ((l == 11) ? 16 : 33);
          run_xfer(1'b1, p[0], s, lr, xid, l[0]);
          xid++;
        end
      end
    end
    report();
  end
endmodule